// File: doc/BRIEF.md
# Dual-Port Token Semaphore Unit

This block gives two independent ports shared access to a small bank of binary token flags. Each flag acts as a lock. A port asks for a flag by writing 0 to it and gives it up by writing 1. Hardware decides which port owns each flag, so software on the two sides never races on a plain memory word. The flags sit in their own address space. A port reaches them with its semaphore select while its memory enable is inactive.

Every flag keeps a waiting request for each side. A port that asks for a flag the other side holds is remembered. When the holder lets go, the token passes straight to the waiting side in the same cycle, with no further write from that side. On a read a port sees its own view of the flag: 0 while it holds the token and 1 otherwise. That bit is copied onto every data line. The read value is latched on the first cycle of the read and stays fixed until the read ends.

Top module: `sema_unit`

## Requirements
- R1: A synchronous reset (`srst` high) frees every flag, clears every waiting request, drives both read buses to 8'h00 and clears both error outputs.
- R2: The flag is chosen by address bits [2:0] only. Address bits above bit 2 have no effect on which flag is written or read.
- R3: A write whose data bit 0 is 0 to a free flag gives that port the token. Its view becomes 0 and the other port's view stays 1. Data bits 7..1 have no effect on any write.
- R4: While one port holds a flag, writes from the other port (0 or 1) do not change either view, and a repeat request (0) from the holder changes nothing.
- R5: When the holder writes 1 and the other port has a waiting request, the token passes to the other port in that same cycle. The old holder's view becomes 1 and the new holder's view becomes 0.
- R6: When the holder writes 1 and no request is waiting, the flag becomes free and both views read 1.
- R7: A write of 1 from a port that is waiting but does not hold the flag withdraws its request. A later release by the holder then frees the flag.
- R8: If both ports write 0 to the same free flag in the same cycle, port A gets the token and port B's request waits. B takes the token when A releases it.
- R9: A read returns the port's view of the addressed flag on all eight data bits (8'hFF or 8'h00). While no read is active the read bus is 8'h00.
- R10: A read is active while select and read enable are both high and the memory enable is low. The value latched in the first active cycle holds unchanged until the read ends, even if the flag or the address changes.
- R11: An access with select and memory enable both high changes no flag and returns no read data. It sets that port's error output, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| a_sel | input | 1 | Port A semaphore select |
| a_mem_en | input | 1 | Port A main-memory enable (must be low for a flag access) |
| a_rd_en | input | 1 | Port A read enable |
| a_wr | input | 1 | Port A write strobe |
| a_addr | input | 16 | Port A address; bits [2:0] pick the flag |
| a_wdata | input | 8 | Port A write data; bit 0 is the flag value |
| a_rdata | output | 8 | Port A read data |
| a_err | output | 1 | Port A sticky illegal-select error |
| b_sel | input | 1 | Port B semaphore select |
| b_mem_en | input | 1 | Port B main-memory enable (must be low for a flag access) |
| b_rd_en | input | 1 | Port B read enable |
| b_wr | input | 1 | Port B write strobe |
| b_addr | input | 16 | Port B address; bits [2:0] pick the flag |
| b_wdata | input | 8 | Port B write data; bit 0 is the flag value |
| b_rdata | output | 8 | Port B read data |
| b_err | output | 1 | Port B sticky illegal-select error |

## Verification
A write sampled at one rising edge updates the flag state at that same edge. The bench therefore starts the following read one cycle later. That read's value appears on the read bus after the next rising edge, and the error output updates at the edge that sampled the illegal select. The bench drives every input on the falling edge and reads the outputs on the falling edge that follows the edge where each result is due. Frozen-read checks compare the bus on several falling edges while a hold is in force, after the underlying flag has changed.

// File: rtl/sema_pkg.sv
package sema_pkg;

    // Which side currently holds a token flag.
    typedef enum logic [1:0] {
        HOLD_NONE = 2'b00,
        HOLD_A    = 2'b01,
        HOLD_B    = 2'b10
    } holder_e;

    // Full state of one flag: holder plus a waiting request per side.
    typedef struct packed {
        holder_e holder;
        logic    wait_a;
        logic    wait_b;
    } tok_t;

    localparam tok_t TOK_FREE = '{holder: HOLD_NONE, wait_a: 1'b0, wait_b: 1'b0};

endpackage

// File: rtl/sema_flag.sv
module sema_flag
    import sema_pkg::*;
(
    input  logic clk,
    input  logic srst,
    input  logic wr_a,
    input  logic bit_a,
    input  logic wr_b,
    input  logic bit_b,
    output logic view_a,
    output logic view_b
);

    tok_t tok_q, tok_d;
    logic ask_a, ask_b;

    always_comb begin
        tok_d = tok_q;
        // releases first: withdraw waits and drop a held token
        if (wr_a && bit_a) tok_d.wait_a = 1'b0;
        if (wr_b && bit_b) tok_d.wait_b = 1'b0;
        if (wr_a && bit_a && tok_q.holder == HOLD_A) tok_d.holder = HOLD_NONE;
        if (wr_b && bit_b && tok_q.holder == HOLD_B) tok_d.holder = HOLD_NONE;
        // live requests: fresh zero writes or remembered waits
        ask_a = (wr_a && !bit_a) || tok_d.wait_a;
        ask_b = (wr_b && !bit_b) || tok_d.wait_b;
        case (tok_d.holder)
            HOLD_NONE: begin
                if (ask_a) begin
                    tok_d.holder = HOLD_A;
                    tok_d.wait_a = 1'b0;
                    tok_d.wait_b = ask_b;
                end else if (ask_b) begin
                    tok_d.holder = HOLD_B;
                    tok_d.wait_b = 1'b0;
                end
            end
            HOLD_A: begin
                tok_d.wait_a = 1'b0;
                tok_d.wait_b = ask_b;
            end
            HOLD_B: begin
                tok_d.wait_b = 1'b0;
                tok_d.wait_a = ask_a;
            end
            default: tok_d = TOK_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (srst) tok_q <= TOK_FREE;
        else      tok_q <= tok_d;
    end

    assign view_a = (tok_q.holder != HOLD_A);
    assign view_b = (tok_q.holder != HOLD_B);

    // R3
    grant_free_chk: assert property (@(posedge clk) disable iff (srst)
        (tok_q.holder == HOLD_NONE && wr_a && !bit_a) |=> !view_a && view_b);

    // R4
    keep_hold_chk: assert property (@(posedge clk) disable iff (srst)
        (tok_q.holder == HOLD_A && !(wr_a && bit_a)) |=> !view_a);

    // R5
    handoff_chk: assert property (@(posedge clk) disable iff (srst)
        (tok_q.holder == HOLD_A && tok_q.wait_b && wr_a && bit_a && !(wr_b && bit_b))
        |=> !view_b && view_a);

    // R6
    free_on_rel_chk: assert property (@(posedge clk) disable iff (srst)
        (tok_q.holder == HOLD_A && !tok_q.wait_b && wr_a && bit_a && !(wr_b && !bit_b))
        |=> view_a && view_b);

    // R8
    tie_to_a_chk: assert property (@(posedge clk) disable iff (srst)
        (tok_q.holder == HOLD_NONE && wr_a && !bit_a && wr_b && !bit_b)
        |=> !view_a && view_b);

endmodule

// File: rtl/sema_port.sv
module sema_port #(
    parameter int NFLAG  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              srst,
    input  logic              sel,
    input  logic              mem_en,
    input  logic              rd_en,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NFLAG-1:0]  view,
    output logic [NFLAG-1:0]  wr_hit,
    output logic              wr_val,
    output logic [DATA_W-1:0] rdata,
    output logic              err
);

    localparam int IDX_W = $clog2(NFLAG);

    typedef struct packed {
        logic              rd_act;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } pst_t;

    pst_t st_q, st_d;

    logic [IDX_W-1:0] idx;
    logic             legal;
    logic             clash;
    logic             rd_now;
    logic             unused_bits;

    assign idx         = addr[IDX_W-1:0];
    assign legal       = sel && !mem_en;
    assign clash       = sel && mem_en;
    assign rd_now      = legal && rd_en;
    assign wr_val      = wdata[0];
    assign unused_bits = ^{addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};

    for (genvar g = 0; g < NFLAG; g++) begin : g_dec
        assign wr_hit[g] = legal && wr && (idx == IDX_W'(g));
    end

    always_comb begin
        st_d        = st_q;
        st_d.rd_act = rd_now;
        if (!rd_now)          st_d.rdata = '0;
        else if (!st_q.rd_act) st_d.rdata = {DATA_W{view[idx]}};
        if (clash)            st_d.err   = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (srst) st_q <= '0;
        else      st_q <= st_d;
    end

    assign rdata = st_q.rdata;
    assign err   = st_q.err;

    // R10
    rd_freeze_chk: assert property (@(posedge clk) disable iff (srst)
        (st_q.rd_act && rd_now) |=> $stable(rdata));

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (srst)
        err |=> err);

    // R2
    one_flag_chk: assert property (@(posedge clk) disable iff (srst)
        $onehot0(wr_hit));

    // R11
    clash_no_rd_chk: assert property (@(posedge clk) disable iff (srst)
        (clash && !st_q.rd_act) |=> rdata == '0);

endmodule

// File: rtl/sema_unit.sv
module sema_unit #(
    parameter int NFLAG  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              srst,
    input  logic              a_sel,
    input  logic              a_mem_en,
    input  logic              a_rd_en,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_err,
    input  logic              b_sel,
    input  logic              b_mem_en,
    input  logic              b_rd_en,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_err
);

    logic [NFLAG-1:0] hit_a, hit_b;
    logic [NFLAG-1:0] view_a, view_b;
    logic             val_a, val_b;

    sema_port #(.NFLAG(NFLAG), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_a (
        .clk(clk), .srst(srst), .sel(a_sel), .mem_en(a_mem_en), .rd_en(a_rd_en),
        .wr(a_wr), .addr(a_addr), .wdata(a_wdata), .view(view_a),
        .wr_hit(hit_a), .wr_val(val_a), .rdata(a_rdata), .err(a_err)
    );

    sema_port #(.NFLAG(NFLAG), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_b (
        .clk(clk), .srst(srst), .sel(b_sel), .mem_en(b_mem_en), .rd_en(b_rd_en),
        .wr(b_wr), .addr(b_addr), .wdata(b_wdata), .view(view_b),
        .wr_hit(hit_b), .wr_val(val_b), .rdata(b_rdata), .err(b_err)
    );

    for (genvar f = 0; f < NFLAG; f++) begin : g_flag
        sema_flag u_flag (
            .clk(clk), .srst(srst),
            .wr_a(hit_a[f]), .bit_a(val_a),
            .wr_b(hit_b[f]), .bit_b(val_b),
            .view_a(view_a[f]), .view_b(view_b[f])
        );
    end

endmodule

// File: tb/sema_unit_bench.sv
module sema_unit_bench;

    logic        clk = 1'b0;
    logic        srst;
    logic        a_sel, a_mem_en, a_rd_en, a_wr;
    logic [15:0] a_addr;
    logic [7:0]  a_wdata;
    logic [7:0]  a_rdata;
    logic        a_err;
    logic        b_sel, b_mem_en, b_rd_en, b_wr;
    logic [15:0] b_addr;
    logic [7:0]  b_wdata;
    logic [7:0]  b_rdata;
    logic        b_err;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    sema_unit u_sema_unit (
        .clk(clk), .srst(srst),
        .a_sel(a_sel), .a_mem_en(a_mem_en), .a_rd_en(a_rd_en), .a_wr(a_wr),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_err(a_err),
        .b_sel(b_sel), .b_mem_en(b_mem_en), .b_rd_en(b_rd_en), .b_wr(b_wr),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_err(b_err)
    );

    // op: 1 = port A writes, 2 = port B writes, 3 = both write
    typedef struct packed {
        logic [1:0] op;
        logic [2:0] flag;
        logic       da;
        logic       db;
        logic       ea;
        logic       eb;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1},  // R3 A takes free flag
        '{2'd2, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1},  // R4 B waits
        '{2'd1, 3'd2, 1'b1, 1'b0, 1'b1, 1'b0},  // R5 handoff to B
        '{2'd2, 3'd2, 1'b0, 1'b1, 1'b1, 1'b1},  // R6 B frees
        '{2'd2, 3'd5, 1'b0, 1'b0, 1'b1, 1'b0},  // R3 B takes free flag
        '{2'd1, 3'd5, 1'b0, 1'b0, 1'b1, 1'b0},  // R4 A waits
        '{2'd1, 3'd5, 1'b1, 1'b0, 1'b1, 1'b0},  // R7 A withdraws
        '{2'd2, 3'd5, 1'b0, 1'b1, 1'b1, 1'b1},  // R7 release frees, no handoff
        '{2'd3, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1},  // R8 tie goes to A
        '{2'd1, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0},  // R8 B's tie request waited
        '{2'd2, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1},  // R6
        '{2'd1, 3'd7, 1'b0, 1'b0, 1'b0, 1'b1},  // R3
        '{2'd2, 3'd7, 1'b0, 1'b1, 1'b0, 1'b1},  // R4 non-holder release
        '{2'd1, 3'd7, 1'b0, 1'b0, 1'b0, 1'b1},  // R4 holder re-request
        '{2'd1, 3'd7, 1'b1, 1'b0, 1'b1, 1'b1}   // R6
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        a_sel = 0; a_mem_en = 0; a_rd_en = 0; a_wr = 0; a_addr = '0; a_wdata = '0;
        b_sel = 0; b_mem_en = 0; b_rd_en = 0; b_wr = 0; b_addr = '0; b_wdata = '0;
    endtask

    // R3: data bits 7..1 are driven opposite to bit 0
    task automatic wr_op(input logic do_a, input logic do_b, input logic [15:0] ad_a,
                         input logic [15:0] ad_b, input logic ba, input logic bb);
        a_sel = do_a; a_wr = do_a; a_addr = ad_a; a_wdata = {{7{~ba}}, ba};
        b_sel = do_b; b_wr = do_b; b_addr = ad_b; b_wdata = {{7{~bb}}, bb};
        @(posedge clk); @(negedge clk);
        idle_inputs();
    endtask

    task automatic rd_both(input logic [15:0] ad_a, input logic [15:0] ad_b,
                           output logic [7:0] ra, output logic [7:0] rb);
        a_sel = 1; a_rd_en = 1; a_addr = ad_a;
        b_sel = 1; b_rd_en = 1; b_addr = ad_b;
        @(posedge clk); @(negedge clk);
        ra = a_rdata; rb = b_rdata;
        idle_inputs();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic do_reset();
        srst = 1'b1;
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        srst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] ra, rb;
        @(negedge clk);
        do_reset();

        // R1 reset state, R9 idle bus
        chk("R1 a_err after reset", {7'd0, a_err}, 8'h00);
        chk("R1 b_err after reset", {7'd0, b_err}, 8'h00);
        chk("R9 a_rdata idle", a_rdata, 8'h00);
        chk("R9 b_rdata idle", b_rdata, 8'h00);
        for (int f = 0; f < 8; f++) begin
            rd_both(16'(f), 16'(f), ra, rb);
            chk("R1 flag free on A", ra, 8'hFF);
            chk("R1 flag free on B", rb, 8'hFF);
        end

        // vector table
        for (int i = 0; i < NV; i++) begin
            wr_op(VEC[i].op[0], VEC[i].op[1], {13'(i * 613), VEC[i].flag},
                  {13'(i * 977), VEC[i].flag}, VEC[i].da, VEC[i].db);
            rd_both({13'(i * 311), VEC[i].flag}, {13'(i * 59), VEC[i].flag}, ra, rb);
            chk($sformatf("vector %0d port A view", i), ra, VEC[i].ea ? 8'hFF : 8'h00);
            chk($sformatf("vector %0d port B view", i), rb, VEC[i].eb ? 8'hFF : 8'h00);
        end

        // R2: upper address bits ignored
        wr_op(1'b1, 1'b0, 16'hABC9, 16'h0000, 1'b0, 1'b0);
        rd_both(16'h0001, 16'hFFF1, ra, rb);
        chk("R2 A holds flag 1", ra, 8'h00);
        chk("R2 B sees flag 1 taken", rb, 8'hFF);
        wr_op(1'b1, 1'b0, 16'h5559, 16'h0000, 1'b1, 1'b0);
        rd_both(16'h7771, 16'h0001, ra, rb);
        chk("R2 flag 1 freed via other alias", ra & rb, 8'hFF);

        // R10: frozen read across handoff and address change
        wr_op(1'b0, 1'b1, 16'h0000, 16'h0004, 1'b0, 1'b0);  // B takes flag 4
        wr_op(1'b1, 1'b0, 16'h0004, 16'h0000, 1'b0, 1'b0);  // A waits
        b_sel = 1; b_rd_en = 1; b_addr = 16'h0004;
        @(posedge clk); @(negedge clk);
        chk("R10 first read value", b_rdata, 8'h00);
        b_wr = 1; b_wdata = 8'h01;                          // release during read
        @(posedge clk); @(negedge clk);
        b_wr = 0; b_wdata = 8'h00; b_addr = 16'h0003;
        @(posedge clk); @(negedge clk);
        chk("R10 held after release", b_rdata, 8'h00);
        @(posedge clk); @(negedge clk);
        chk("R10 held after address change", b_rdata, 8'h00);
        b_rd_en = 0;
        @(posedge clk); @(negedge clk);
        chk("R9 bus low after read ends", b_rdata, 8'h00);
        b_rd_en = 1; b_addr = 16'h0004;
        @(posedge clk); @(negedge clk);
        chk("R10 fresh read after toggle", b_rdata, 8'hFF);
        idle_inputs();
        rd_both(16'h0004, 16'h0004, ra, rb);
        chk("R5 A got flag 4 by handoff", ra, 8'h00);
        wr_op(1'b1, 1'b0, 16'h0004, 16'h0000, 1'b1, 1'b0);

        // R11: select with memory enable is illegal
        a_sel = 1; a_mem_en = 1; a_wr = 1; a_addr = 16'h0006; a_wdata = 8'h00;
        @(posedge clk); @(negedge clk);
        chk("R11 a_err set", {7'd0, a_err}, 8'h01);
        chk("R11 b_err untouched", {7'd0, b_err}, 8'h00);
        a_wr = 0; a_rd_en = 1;
        @(posedge clk); @(negedge clk);
        chk("R11 no read data on clash", a_rdata, 8'h00);
        idle_inputs();
        rd_both(16'h0006, 16'h0006, ra, rb);
        chk("R11 flag 6 unchanged on A", ra, 8'hFF);
        chk("R11 flag 6 unchanged on B", rb, 8'hFF);
        chk("R11 a_err sticky", {7'd0, a_err}, 8'h01);

        // R1: reset frees held flags and clears error
        wr_op(1'b1, 1'b1, 16'h0001, 16'h0002, 1'b0, 1'b0);
        do_reset();
        chk("R1 a_err cleared", {7'd0, a_err}, 8'h00);
        rd_both(16'h0001, 16'h0002, ra, rb);
        chk("R1 flag 1 free after reset", ra, 8'hFF);
        chk("R1 flag 2 free after reset", rb, 8'hFF);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule